// File: doc/BRIEF.md
# Shared Accelerator Allocation Manager

This block is the central arbiter for a pool of shared accelerator instances. Each instance has a fixed type code, set at elaboration. Cores reach the manager through a two-phase protocol. A core first sends a query that carries only a type code. The manager answers with one of two things:

- the set of instances of that type, one suggested instance and an estimated wait;
- a refusal, when no instance of that type exists.

The core then sends a reservation that names the type and the instance it chose. If the reservation is valid, the manager acknowledges it and, in the same cycle, tells the accelerator side which core now owns that instance. When the core is done it sends a release message, and the instance becomes free again.

Starting the accelerator and exchanging task descriptors happen directly between the core and the accelerator. The manager takes no part in that step.

The manager takes at most one core message per cycle. Each core has its own valid/ready pair, and cores are served in round-robin order. For each instance the manager keeps:

- a busy bit;
- the owner core ID;
- a remaining-busy down-counter, loaded from the estimate the core supplies with its reservation.

When every matching instance is busy, the wait estimate comes from these counters.

Top module: `accel_alloc_mgr`

## Requirements
- R1: A query (op code 0) carrying a type code is answered one cycle after acceptance. The reply has rsp_valid high, rsp_code 0 (list), and bit i of rsp_cand set exactly for each instance i whose type equals the queried type. With the default parameters, instances 0 and 1 are type 0, instance 2 is type 1 and instance 3 is type 2.
- R2: A query for a type with no instance is answered with rsp_code 2 (refusal) and rsp_cand all zero.
- R3: In a list reply, when any matching instance is free, rsp_pick is the lowest-index free matching instance and rsp_wait is 0.
- R4: A valid reservation (op code 1) is answered with rsp_code 1 (acknowledge). In the same cycle own_valid is high, with own_inst set to the reserved instance and own_core set to the requesting core.
- R5: A reservation is refused (rsp_code 2) and changes no state in either of two cases: the named instance is owned by a different core, or its type differs from the type in the message.
- R6: A release (op code 2) from the owning core frees the instance, so a later reservation of it by another core is acknowledged. A release from any other core is ignored and pulses err_flag for one cycle. A release never produces a response.
- R7: At most one core_ready bit is high in a cycle, and only for a core with core_valid high. Grants rotate round-robin, starting from the core after the last one granted. After reset, core 0 has first priority.
- R8: When every matching instance is busy, rsp_pick is the matching instance with the smallest remaining-busy counter and rsp_wait is that counter's value. A reservation loads the counter with its estimate. The counter then drops by one each cycle until it reaches zero.
- R9: During and right after reset, rsp_valid, own_valid and err_flag are low and every instance is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | NUM_CORES | Per-core message valid |
| core_op | input | 2*NUM_CORES | Per-core op: 0 query, 1 reserve, 2 release |
| core_type | input | TYPE_W*NUM_CORES | Per-core accelerator type code |
| core_inst | input | INST_W*NUM_CORES | Per-core instance index (reserve, release) |
| core_est | input | WAIT_W*NUM_CORES | Per-core busy-time estimate (reserve) |
| core_ready | output | NUM_CORES | Per-core message accepted this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_core | output | CORE_W | Core the response is addressed to |
| rsp_code | output | 2 | 0 list, 1 acknowledge, 2 refusal |
| rsp_cand | output | NUM_INST | Instances of the queried type |
| rsp_pick | output | INST_W | Suggested instance |
| rsp_wait | output | WAIT_W | Estimated wait in cycles |
| own_valid | output | 1 | Owner notification to an accelerator |
| own_inst | output | INST_W | Instance that was reserved |
| own_core | output | CORE_W | Core that now owns it |
| err_flag | output | 1 | One-cycle pulse on a release from a non-owner |

## Verification
The bench covers the following corner cases, each with the fault it would catch:

- A second core reserving an instance that is already taken. A design that checked only the type would hand one accelerator to two cores.
- A reservation that names an instance of the wrong type. This would slip through if the type check were dropped.
- A release from a core that does not own the instance. A design without the ownership check would free the instance, and a later reservation by a third core would then be wrongly refused or wrongly acknowledged.
- The wait estimate, read at two known counter values and with a free instance present. A wrong down-counter load or decrement, or a free-first ordering that is ignored, shows up as a wrong wait or pick.
- Two cores asking in the same cycle. A fixed-priority arbiter would show here as a different grant order.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
   typedef enum logic [1:0] {
      OP_QUERY   = 2'd0,
      OP_RESERVE = 2'd1,
      OP_FREE    = 2'd2
   } op_e;

   typedef enum logic [1:0] {
      RSP_LIST = 2'd0,
      RSP_ACK  = 2'd1,
      RSP_NACK = 2'd2
   } rsp_e;
endpackage

// File: rtl/rr_arb.sv
module rr_arb #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gnt_idx,
   output logic          any
);
   logic [IW-1:0] last;

   always_comb begin
      gnt     = '0;
      gnt_idx = last;
      any     = 1'b0;
      for (int k = 1; k <= N; k++) begin
         int j;
         j = (int'(last) + k) % N;
         if (!any && req[j]) begin
            any     = 1'b1;
            gnt[j]  = 1'b1;
            gnt_idx = IW'(j);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last <= IW'(N - 1);
      else if (any) last <= gnt_idx;
   end

   // R7
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   // R7
   grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
endmodule

// File: rtl/inst_slot.sv
module inst_slot #(
   parameter int CORE_W = 2,
   parameter int WAIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              drop,
   input  logic [CORE_W-1:0] core_in,
   input  logic [WAIT_W-1:0] est_in,
   output logic              busy,
   output logic [CORE_W-1:0] owner,
   output logic [WAIT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         owner <= '0;
         cnt   <= '0;
      end else if (take) begin
         busy  <= 1'b1;
         owner <= core_in;
         cnt   <= est_in;
      end else if (drop) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   // R8
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt > $past(cnt)) |-> $past(take));
   // R6
   free_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(drop));
endmodule

// File: rtl/cand_scan.sv
module cand_scan #(
   parameter int NUM_INST = 4,
   parameter int WAIT_W   = 8,
   localparam int INST_W  = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
   input  logic [NUM_INST-1:0]        match,
   input  logic [NUM_INST-1:0]        busy,
   input  logic [NUM_INST*WAIT_W-1:0] cnt_flat,
   output logic [INST_W-1:0]          pick,
   output logic [WAIT_W-1:0]          wait_est
);
   always_comb begin
      logic hit_free;
      logic have;
      logic [WAIT_W-1:0] best;
      hit_free = 1'b0;
      have     = 1'b0;
      best     = '1;
      pick     = '0;
      for (int i = 0; i < NUM_INST; i++) begin
         if (match[i] && !busy[i] && !hit_free) begin
            hit_free = 1'b1;
            pick     = INST_W'(i);
         end
      end
      if (!hit_free) begin
         for (int i = 0; i < NUM_INST; i++) begin
            if (match[i] && (!have || cnt_flat[i*WAIT_W +: WAIT_W] < best)) begin
               have = 1'b1;
               best = cnt_flat[i*WAIT_W +: WAIT_W];
               pick = INST_W'(i);
            end
         end
      end
      wait_est = hit_free ? '0 : best;
   end
endmodule

// File: rtl/accel_alloc_mgr.sv
module accel_alloc_mgr
   import alloc_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int NUM_INST  = 4,
   parameter int TYPE_W    = 2,
   parameter int WAIT_W    = 8,
   parameter logic [NUM_INST*TYPE_W-1:0] INST_TYPES = 8'b10_01_00_00,
   localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int INST_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CORES-1:0]          core_valid,
   input  logic [2*NUM_CORES-1:0]        core_op,
   input  logic [TYPE_W*NUM_CORES-1:0]   core_type,
   input  logic [INST_W*NUM_CORES-1:0]   core_inst,
   input  logic [WAIT_W*NUM_CORES-1:0]   core_est,
   output logic [NUM_CORES-1:0]          core_ready,
   output logic                          rsp_valid,
   output logic [CORE_W-1:0]             rsp_core,
   output logic [1:0]                    rsp_code,
   output logic [NUM_INST-1:0]           rsp_cand,
   output logic [INST_W-1:0]             rsp_pick,
   output logic [WAIT_W-1:0]             rsp_wait,
   output logic                          own_valid,
   output logic [INST_W-1:0]             own_inst,
   output logic [CORE_W-1:0]             own_core,
   output logic                          err_flag
);
   generate
      if (NUM_CORES < 2) begin : g_bad_cores
         $error("NUM_CORES must be at least 2");
      end
      if (NUM_INST < 2) begin : g_bad_inst
         $error("NUM_INST must be at least 2");
      end
      if (WAIT_W < 1 || TYPE_W < 1) begin : g_bad_width
         $error("TYPE_W and WAIT_W must be positive");
      end
   endgenerate

   logic              any;
   logic [CORE_W-1:0] sel;
   rr_arb #(.N(NUM_CORES)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(core_valid),
      .gnt(core_ready), .gnt_idx(sel), .any(any)
   );

   op_e               s_op;
   logic [TYPE_W-1:0] s_type;
   logic [INST_W-1:0] s_inst;
   logic [WAIT_W-1:0] s_est;
   always_comb begin
      s_op   = op_e'(core_op[sel*2 +: 2]);
      s_type = core_type[sel*TYPE_W +: TYPE_W];
      s_inst = core_inst[sel*INST_W +: INST_W];
      s_est  = core_est[sel*WAIT_W +: WAIT_W];
   end

   logic [NUM_INST-1:0]        match, busy, take, drop;
   logic [NUM_INST*CORE_W-1:0] owner_flat;
   logic [NUM_INST*WAIT_W-1:0] cnt_flat;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_INST; gi++) begin : g_slot
         assign match[gi] = (INST_TYPES[gi*TYPE_W +: TYPE_W] == s_type);
         inst_slot #(.CORE_W(CORE_W), .WAIT_W(WAIT_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .take(take[gi]), .drop(drop[gi]),
            .core_in(sel), .est_in(s_est),
            .busy(busy[gi]),
            .owner(owner_flat[gi*CORE_W +: CORE_W]),
            .cnt(cnt_flat[gi*WAIT_W +: WAIT_W])
         );
      end
   endgenerate

   logic [INST_W-1:0] scan_pick;
   logic [WAIT_W-1:0] scan_wait;
   cand_scan #(.NUM_INST(NUM_INST), .WAIT_W(WAIT_W)) u_scan (
      .match(match), .busy(busy), .cnt_flat(cnt_flat),
      .pick(scan_pick), .wait_est(scan_wait)
   );

   logic inst_ok, own_ok, res_ok;
   always_comb begin
      inst_ok = ({1'b0, s_inst} < (INST_W+1)'(NUM_INST));
      own_ok  = inst_ok && busy[s_inst] &&
                (owner_flat[s_inst*CORE_W +: CORE_W] == sel);
      res_ok  = inst_ok && match[s_inst] && (!busy[s_inst] || own_ok);
      take    = '0;
      drop    = '0;
      if (any && s_op == OP_RESERVE && res_ok) take[s_inst] = 1'b1;
      if (any && s_op == OP_FREE && own_ok)    drop[s_inst] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_core  <= '0;
         rsp_code  <= RSP_LIST;
         rsp_cand  <= '0;
         rsp_pick  <= '0;
         rsp_wait  <= '0;
         own_valid <= 1'b0;
         own_inst  <= '0;
         own_core  <= '0;
         err_flag  <= 1'b0;
      end else begin
         rsp_valid <= any && (s_op == OP_QUERY || s_op == OP_RESERVE);
         rsp_core  <= sel;
         rsp_cand  <= '0;
         rsp_pick  <= '0;
         rsp_wait  <= '0;
         own_valid <= any && s_op == OP_RESERVE && res_ok;
         own_inst  <= s_inst;
         own_core  <= sel;
         err_flag  <= any && s_op == OP_FREE && !own_ok;
         if (s_op == OP_QUERY) begin
            rsp_code <= (match == '0) ? RSP_NACK : RSP_LIST;
            rsp_cand <= match;
            rsp_pick <= scan_pick;
            rsp_wait <= scan_wait;
         end else begin
            rsp_code <= res_ok ? RSP_ACK : RSP_NACK;
            rsp_pick <= s_inst;
         end
      end
   end

   // R4
   own_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      own_valid |-> (rsp_valid && rsp_code == RSP_ACK && rsp_core == own_core));
   // R6
   free_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> !rsp_valid);
   // R2
   list_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == RSP_LIST) |-> (rsp_cand != '0));
   // R3
   pick_in_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == RSP_LIST) |-> rsp_cand[rsp_pick]);
   // R7
   rsp_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(core_ready != '0));
endmodule

// File: tb/accel_alloc_mgr_bench.sv
module accel_alloc_mgr_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 4, NI = 4, TW = 2, WW = 8, CW = 2, IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NC-1:0]    core_valid = '0;
   logic [2*NC-1:0]  core_op = '0;
   logic [TW*NC-1:0] core_type = '0;
   logic [IW*NC-1:0] core_inst = '0;
   logic [WW*NC-1:0] core_est = '0;
   logic [NC-1:0]    core_ready;
   logic             rsp_valid, own_valid, err_flag;
   logic [CW-1:0]    rsp_core, own_core;
   logic [1:0]       rsp_code;
   logic [NI-1:0]    rsp_cand;
   logic [IW-1:0]    rsp_pick, own_inst;
   logic [WW-1:0]    rsp_wait;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   accel_alloc_mgr u_accel_alloc_mgr (
      .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_op(core_op),
      .core_type(core_type), .core_inst(core_inst), .core_est(core_est),
      .core_ready(core_ready), .rsp_valid(rsp_valid), .rsp_core(rsp_core),
      .rsp_code(rsp_code), .rsp_cand(rsp_cand), .rsp_pick(rsp_pick),
      .rsp_wait(rsp_wait), .own_valid(own_valid), .own_inst(own_inst),
      .own_core(own_core), .err_flag(err_flag)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input int c, input int op, input int ty, input int inst, input int est);
      core_valid[c]        = 1'b1;
      core_op[c*2 +: 2]    = 2'(op);
      core_type[c*TW +: TW] = TW'(ty);
      core_inst[c*IW +: IW] = IW'(inst);
      core_est[c*WW +: WW] = WW'(est);
   endtask

   // send one message; returns just after the accepting edge
   task automatic send(input int c, input int op, input int ty, input int inst, input int est);
      @(negedge clk);
      drive(c, op, ty, inst, est);
      #1;
      while (!core_ready[c]) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      core_valid[c] = 1'b0;
   endtask

   task automatic t_reset;
      check(rsp_valid == 0, "R9 rsp_valid", rsp_valid, 0);
      check(own_valid == 0, "R9 own_valid", own_valid, 0);
      check(err_flag == 0, "R9 err_flag", err_flag, 0);
      check(core_ready == 0, "R9 core_ready", core_ready, 0);
   endtask

   task automatic t_query_absent;
      send(0, 0, 3, 0, 0);
      check(rsp_valid && rsp_code == 2, "R2 refusal code", rsp_code, 2);
      check(rsp_cand == 0, "R2 empty mask", rsp_cand, 0);
   endtask

   task automatic t_query_free;
      send(1, 0, 0, 0, 0);
      check(rsp_valid && rsp_code == 0 && rsp_core == 1, "R1 list reply", rsp_code, 0);
      check(rsp_cand == 4'b0011, "R1 type0 mask", rsp_cand, 3);
      check(rsp_pick == 0 && rsp_wait == 0, "R3 lowest free", rsp_pick, 0);
      send(2, 0, 2, 0, 0);
      check(rsp_cand == 4'b1000, "R1 type2 mask", rsp_cand, 8);
   endtask

   task automatic t_reserve;
      send(0, 1, 0, 0, 200);
      check(rsp_valid && rsp_code == 1, "R4 ack", rsp_code, 1);
      check(own_valid && own_inst == 0 && own_core == 0, "R4 owner notify", own_core, 0);
      send(1, 0, 0, 0, 0);
      check(rsp_pick == 1 && rsp_wait == 0, "R3 free first", rsp_pick, 1);
      send(1, 1, 0, 0, 7);
      check(rsp_code == 2 && !own_valid, "R5 owned by other", rsp_code, 2);
      send(1, 1, 0, 1, 3);
      check(rsp_code == 1 && own_inst == 1 && own_core == 1, "R4 ack inst1", own_core, 1);
      send(3, 1, 0, 2, 5);
      check(rsp_code == 2 && !own_valid, "R5 type mismatch", rsp_code, 2);
   endtask

   task automatic t_wait;
      send(3, 1, 1, 2, 10);
      check(rsp_code == 1 && own_inst == 2 && own_core == 3, "R4 ack inst2", own_inst, 2);
      send(1, 0, 1, 0, 0);
      check(rsp_pick == 2 && rsp_wait == 10, "R8 wait full", rsp_wait, 10);
      repeat (4) @(posedge clk);
      #1;
      send(1, 0, 1, 0, 0);
      check(rsp_wait == 5, "R8 wait counted down", rsp_wait, 5);
      repeat (10) @(posedge clk);
      #1;
      send(2, 0, 0, 0, 0);
      check(rsp_cand == 4'b0011 && rsp_pick == 1, "R8 smallest counter", rsp_pick, 1);
   endtask

   task automatic t_release;
      send(2, 2, 0, 0, 0);
      check(err_flag == 1, "R6 non-owner err", err_flag, 1);
      check(rsp_valid == 0, "R6 no response", rsp_valid, 0);
      send(2, 1, 0, 0, 4);
      check(rsp_code == 2, "R6 non-owner ignored", rsp_code, 2);
      send(1, 2, 0, 1, 0);
      check(err_flag == 0 && rsp_valid == 0, "R6 owner release", err_flag, 0);
      send(3, 1, 0, 1, 4);
      check(rsp_code == 1 && own_core == 3 && own_inst == 1, "R6 freed reusable", rsp_code, 1);
   endtask

   task automatic t_round_robin;
      @(negedge clk);
      drive(1, 0, 0, 0, 0);
      drive(2, 0, 1, 0, 0);
      #1;
      check(core_ready == 4'b0010, "R7 first grant", core_ready, 2);
      @(posedge clk);
      #1;
      core_valid[1] = 1'b0;
      check(rsp_core == 1, "R7 rsp core1", rsp_core, 1);
      @(negedge clk);
      check(core_ready == 4'b0100, "R7 second grant", core_ready, 4);
      @(posedge clk);
      #1;
      core_valid[2] = 1'b0;
      check(rsp_core == 2 && rsp_cand == 4'b0100, "R7 rsp core2", rsp_core, 2);
      @(negedge clk);
      drive(0, 0, 2, 0, 0);
      drive(3, 0, 2, 0, 0);
      #1;
      check(core_ready == 4'b1000, "R7 rotate past last", core_ready, 8);
      @(posedge clk);
      #1;
      core_valid[3] = 1'b0;
      @(negedge clk);
      check(core_ready == 4'b0001, "R7 then core0", core_ready, 1);
      @(posedge clk);
      #1;
      core_valid[0] = 1'b0;
      check(rsp_core == 0, "R7 rsp core0", rsp_core, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset;
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset;
      t_query_absent;
      t_query_free;
      t_reserve;
      t_wait;
      t_release;
      t_round_robin;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule